// File: doc/BRIEF.md
# Clock Stop and Restart Sequencer

This controller parks a clocked subsystem in a low-power state with its clock halted and brings it back later. It runs on an always-on control clock. A sleep request starts a fixed sequence. New transactions are refused first, and the sequencer waits for outstanding ones to finish. Then the registers that must keep their state lose their clock enable, and the logic that need not survive is held in reset. The gated clock is switched off only while the clock is low. Last, the delay-locked loop that generates the clock is put into reset, because a stopped loop drifts with voltage and temperature and cannot be trusted to keep lock.

A wake request releases the loop reset and waits for lock. When lock is seen, the clock gate reopens and the freeze and reset outputs drop on the same control-clock edge. New transactions are accepted one cycle after that. A programmable timeout guards the relock. If lock is late, the sequencer raises an error flag, pulses the loop reset again and retries. A wake that arrives while the block is still going to sleep is remembered, and the sequencer restarts as soon as the stop is complete. The clock-gating cell and the loop sit outside the block.

Top module: `clk_stop_seq`

## Requirements
- R1: After reset the block is in RUN with block_txn=0, freeze=0, logic_rst=0, gate_en=1, dll_rst=0 and lock_err=0.
- R2: A sleep request in RUN raises block_txn and moves to DRAIN. The block stays in DRAIN, with freeze low, while txn_pending is high.
- R3: Once txn_pending is low in DRAIN, freeze and logic_rst rise together on the next edge, and block_txn is already high.
- R4: gate_en changes only on an edge where src_clk_lvl is sampled low. In FREEZE with src_clk_lvl high, gate_en stays 1.
- R5: dll_rst rises at least one cycle after gate_en has fallen and is never high while gate_en is high. Each reset pulse lasts exactly RST_CYC cycles (default 4) before a relock may begin.
- R6: A wake request in STOPPED releases dll_rst and moves to RELOCK. freeze stays high and gate_en stays low until the synchronized lock is seen.
- R7: When lock is seen and src_clk_lvl is low, freeze and logic_rst fall and gate_en rises on one edge. block_txn falls one cycle later, unless a new sleep request is present.
- R8: If lock_tmo is nonzero and lock is not seen within lock_tmo cycles of entering RELOCK, the block enters ERROR with lock_err=1 and dll_rst=1. After the reset pulse it retries RELOCK. lock_err stays high until RUN is reached again. A value of 0 disables the timeout.
- R9: A wake request seen in DRAIN or FREEZE is latched. After the stop and the loop reset pulse complete, the block relocks without a further request.
- R10: state_o encodes RUN=0, DRAIN=1, FREEZE=2, STOPPED=3, RELOCK=4, ERROR=5 and never shows any other value.
- R11: A wake request in RUN has no effect; the state and all outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter the stopped state (level) |
| wake_req | input | 1 | Request to leave the stopped state (level) |
| txn_pending | input | 1 | Subsystem still has transactions in flight |
| dll_locked | input | 1 | Lock indication from the loop (asynchronous) |
| src_clk_lvl | input | 1 | Sampled level of the clock ahead of the gate |
| lock_tmo | input | TMO_W | Relock timeout in control cycles, 0 disables it |
| block_txn | output | 1 | Refuse new transactions |
| freeze | output | 1 | Removes the clock enable of preserved registers |
| logic_rst | output | 1 | Reset for non-preserved logic |
| gate_en | output | 1 | Clock-gate enable |
| dll_rst | output | 1 | Reset for the loop |
| lock_err | output | 1 | Relock timed out since the last return to RUN |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bench aims at the ordering hazards. If freeze rose before draining finished, writes in flight would be lost. If the gate closed while the source clock was high, the subsystem would see a runt pulse. If the loop reset were asserted with the clock still passing, the design would run on an unlocked clock. If transactions were accepted on the same edge as the unfreeze, the first access would land in a register that was still frozen. It also measures the exact reset pulse width and the exact cycle count of the relock timeout, where an off-by-one design would give a short reset or an early error. Finally, it checks that a wake pulse arriving mid-drain is not dropped, since a design that ignored it would stay stopped forever.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_FREEZE  = 3'd2,
      ST_STOPPED = 3'd3,
      ST_RELOCK  = 3'd4,
      ST_ERROR   = 3'd5
   } seq_state_e;

   localparam int unsigned STATE_W = 3;

endpackage

// File: rtl/clkseq_sync.sv
// Multi-stage synchronizer for an asynchronous level.
module clkseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clkseq_counter.sv
// Saturating cycle counter, cleared whenever run is low.
module clkseq_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   output logic [W-1:0] count
);

   if (W < 1) begin : g_bad_width
      $error("clkseq_counter: W must be at least 1");
   end

   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (!run)              count <= '0;
      else if (count != CNT_MAX)  count <= count + 1'b1;
   end

endmodule

// File: rtl/clkseq_fsm.sv
// Sequencing state machine with registered outputs.
module clkseq_fsm
   import clkseq_pkg::*;
#(
   parameter int unsigned TMO_W = 16,
   parameter int unsigned RST_W = 3,
   parameter int unsigned RST_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic             txn_pending,
   input  logic             lock_s,
   input  logic             src_lvl,
   input  logic [TMO_W-1:0] lock_tmo,
   input  logic [TMO_W-1:0] lock_cnt,
   input  logic [RST_W-1:0] rst_cnt,
   output seq_state_e       st,
   output logic             lock_run,
   output logic             block_o,
   output logic             freeze_o,
   output logic             lrst_o,
   output logic             gate_o,
   output logic             dllrst_o,
   output logic             err_o
);

   localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_CYC - 1);

   seq_state_e nxt;
   logic       wake_pend;
   logic       rst_done;
   logic       tmo_hit;
   logic       wake_any;
   logic       frozen_nxt;

   assign rst_done = dllrst_o && (rst_cnt >= RST_LAST);
   assign tmo_hit  = (lock_tmo != '0) && (lock_cnt >= (lock_tmo - 1'b1));
   assign wake_any = wake_req || wake_pend;
   assign lock_run = (st == ST_RELOCK);

   always_comb begin
      nxt = st;
      unique case (st)
         ST_RUN:     if (sleep_req)             nxt = ST_DRAIN;
         ST_DRAIN:   if (!txn_pending)          nxt = ST_FREEZE;
         ST_FREEZE:  if (!src_lvl)              nxt = ST_STOPPED;
         ST_STOPPED: if (wake_any && rst_done)  nxt = ST_RELOCK;
         ST_RELOCK: begin
            if (lock_s && !src_lvl)             nxt = ST_RUN;
            else if (tmo_hit)                   nxt = ST_ERROR;
         end
         ST_ERROR:   if (rst_done)              nxt = ST_RELOCK;
         default:                               nxt = ST_RUN;
      endcase
   end

   assign frozen_nxt = (nxt == ST_FREEZE) || (nxt == ST_STOPPED) ||
                       (nxt == ST_RELOCK) || (nxt == ST_ERROR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         block_o   <= 1'b0;
         freeze_o  <= 1'b0;
         lrst_o    <= 1'b0;
         gate_o    <= 1'b1;
         dllrst_o  <= 1'b0;
         err_o     <= 1'b0;
         wake_pend <= 1'b0;
      end else begin
         st       <= nxt;
         block_o  <= (nxt != ST_RUN) || (st != ST_RUN);
         freeze_o <= frozen_nxt;
         lrst_o   <= frozen_nxt;
         dllrst_o <= ((st == ST_STOPPED) && (nxt == ST_STOPPED)) ||
                     (nxt == ST_ERROR);
         if (st == ST_FREEZE && nxt == ST_STOPPED)     gate_o <= 1'b0;
         else if (st == ST_RELOCK && nxt == ST_RUN)    gate_o <= 1'b1;
         if (nxt == ST_ERROR)                          err_o <= 1'b1;
         else if (nxt == ST_RUN)                       err_o <= 1'b0;
         if (st == ST_STOPPED && nxt == ST_RELOCK)     wake_pend <= 1'b0;
         else if (wake_req && (st == ST_DRAIN || st == ST_FREEZE ||
                               st == ST_STOPPED))      wake_pend <= 1'b1;
      end
   end

endmodule

// File: rtl/clk_stop_seq.sv
// Top level: clock stop and restart sequencer.
module clk_stop_seq
   import clkseq_pkg::*;
#(
   parameter int unsigned TMO_W       = 16,
   parameter int unsigned RST_CYC     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic             txn_pending,
   input  logic             dll_locked,
   input  logic             src_clk_lvl,
   input  logic [TMO_W-1:0] lock_tmo,
   output logic             block_txn,
   output logic             freeze,
   output logic             logic_rst,
   output logic             gate_en,
   output logic             dll_rst,
   output logic             lock_err,
   output logic [2:0]       state_o
);

   localparam int unsigned RST_W = $clog2(RST_CYC + 1);

   if (RST_CYC < 1) begin : g_bad_rst
      $error("clk_stop_seq: RST_CYC must be at least 1");
   end
   if (TMO_W < 2) begin : g_bad_tmo
      $error("clk_stop_seq: TMO_W must be at least 2");
   end

   seq_state_e       st;
   logic             lock_s;
   logic             lock_run;
   logic [TMO_W-1:0] lock_cnt;
   logic [RST_W-1:0] rst_cnt;

   clkseq_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dll_locked),
      .q     (lock_s)
   );

   clkseq_counter #(.W(TMO_W)) u_lock_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (lock_run),
      .count (lock_cnt)
   );

   clkseq_counter #(.W(RST_W)) u_rst_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (dll_rst),
      .count (rst_cnt)
   );

   clkseq_fsm #(
      .TMO_W   (TMO_W),
      .RST_W   (RST_W),
      .RST_CYC (RST_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .wake_req    (wake_req),
      .txn_pending (txn_pending),
      .lock_s      (lock_s),
      .src_lvl     (src_clk_lvl),
      .lock_tmo    (lock_tmo),
      .lock_cnt    (lock_cnt),
      .rst_cnt     (rst_cnt),
      .st          (st),
      .lock_run    (lock_run),
      .block_o     (block_txn),
      .freeze_o    (freeze),
      .lrst_o      (logic_rst),
      .gate_o      (gate_en),
      .dllrst_o    (dll_rst),
      .err_o       (lock_err)
   );

   assign state_o = st;

endmodule

// File: rtl/clk_stop_seq_chk.sv
// Property checker attached to the sequencer top.
module clk_stop_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_req,
   input logic       txn_pending,
   input logic       src_clk_lvl,
   input logic       block_txn,
   input logic       freeze,
   input logic       gate_en,
   input logic       dll_rst,
   input logic       lock_err,
   input logic [2:0] state_o
);

   p_freeze_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> block_txn);

   p_freeze_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze) |-> $past(!txn_pending));

   p_gate_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_en) |-> $past(!src_clk_lvl));

   p_dllrst_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dll_rst |-> !gate_en);

   p_dllrst_after_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dll_rst) |-> $past(!gate_en));

   p_accept_after_unfreeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(freeze) && !sleep_req) |=> !block_txn);

   p_block_falls_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(block_txn) |-> $past(!freeze));

   p_err_with_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_err) |-> dll_rst);

   p_legal_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd5);

endmodule

bind clk_stop_seq clk_stop_seq_chk u_chk (.*);

// File: tb/clk_stop_seq_tb.sv
module clk_stop_seq_tb;

   localparam int unsigned TMO_W   = 16;
   localparam int unsigned RST_CYC = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sleep_req = 1'b0;
   logic             wake_req = 1'b0;
   logic             txn_pending = 1'b0;
   logic             dll_locked;
   logic             src_clk_lvl = 1'b0;
   logic [TMO_W-1:0] lock_tmo = '0;
   logic             block_txn, freeze, logic_rst, gate_en, dll_rst, lock_err;
   logic [2:0]       state_o;

   int               n_vec = 0;
   int               n_bad = 0;
   int               lock_dly = 8;
   int               lock_ctr = 0;
   bit               done = 1'b0;

   always #4 clk = ~clk;

   clk_stop_seq #(.TMO_W(TMO_W), .RST_CYC(RST_CYC)) u_dut (
      .clk, .rst_n, .sleep_req, .wake_req, .txn_pending, .dll_locked,
      .src_clk_lvl, .lock_tmo, .block_txn, .freeze, .logic_rst, .gate_en,
      .dll_rst, .lock_err, .state_o
   );

   // Loop model: lock arrives lock_dly cycles after its reset is released.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_ctr   <= 0;
         dll_locked <= 1'b0;
      end else if (dll_rst) begin
         lock_ctr   <= 0;
         dll_locked <= 1'b0;
      end else begin
         if (lock_ctr < lock_dly) lock_ctr <= lock_ctr + 1;
         dll_locked <= (lock_ctr >= lock_dly);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Fields: sleep, wake, pend, lvl, wait[7:0], state[2:0], block, freeze, gate, dllrst
   localparam int NV = 10;
   localparam logic [18:0] VEC [NV] = '{
      {1'b0,1'b0,1'b0,1'b0, 8'd4,  3'd0, 1'b0,1'b0,1'b1,1'b0},  // idle, R1
      {1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd0, 1'b0,1'b0,1'b1,1'b0},  // wake in RUN, R11
      {1'b1,1'b0,1'b1,1'b1, 8'd6,  3'd1, 1'b1,1'b0,1'b1,1'b0},  // drain held, R2
      {1'b1,1'b0,1'b0,1'b1, 8'd6,  3'd2, 1'b1,1'b1,1'b1,1'b0},  // frozen, clock high, R3 R4
      {1'b1,1'b0,1'b0,1'b0, 8'd6,  3'd3, 1'b1,1'b1,1'b0,1'b1},  // stopped, R5
      {1'b0,1'b0,1'b0,1'b0, 8'd20, 3'd3, 1'b1,1'b1,1'b0,1'b1},  // stays stopped
      {1'b0,1'b1,1'b0,1'b0, 8'd40, 3'd0, 1'b0,1'b0,1'b1,1'b0},  // wake and relock, R6
      {1'b0,1'b0,1'b0,1'b0, 8'd4,  3'd0, 1'b0,1'b0,1'b1,1'b0},
      {1'b1,1'b0,1'b0,1'b0, 8'd10, 3'd3, 1'b1,1'b1,1'b0,1'b1},  // fast path to stop
      {1'b0,1'b1,1'b0,1'b0, 8'd40, 3'd0, 1'b0,1'b0,1'b1,1'b0}   // wake again, R6
   };

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int k;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R1 and R10: reset state
      check("R1 state", state_o, 0);
      check("R1 block_txn", block_txn, 0);
      check("R1 freeze", freeze, 0);
      check("R1 logic_rst", logic_rst, 0);
      check("R1 gate_en", gate_en, 1);
      check("R1 dll_rst", dll_rst, 0);
      check("R1 lock_err", lock_err, 0);
      cycles(12);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         sleep_req   = VEC[i][18];
         wake_req    = VEC[i][17];
         txn_pending = VEC[i][16];
         src_clk_lvl = VEC[i][15];
         cycles(int'(VEC[i][14:7]));
         check("R10 vector state", state_o, int'(VEC[i][6:4]));
         check("R2 vector block_txn", block_txn, int'(VEC[i][3]));
         check("R3 vector freeze", freeze, int'(VEC[i][2]));
         check("R3 vector logic_rst", logic_rst, int'(VEC[i][2]));
         check("R4 vector gate_en", gate_en, int'(VEC[i][1]));
         check("R5 vector dll_rst", dll_rst, int'(VEC[i][0]));
      end
      wake_req = 1'b0;
      cycles(4);

      // R9 with R5: wake pulse during drain is latched; reset pulse width
      sleep_req = 1'b1; txn_pending = 1'b1; src_clk_lvl = 1'b1;
      cycles(3);
      sleep_req = 1'b0;
      wake_req = 1'b1;
      cycles(1);
      wake_req = 1'b0;
      cycles(3);
      check("R9 still draining", state_o, 1);
      txn_pending = 1'b0;
      cycles(4);
      check("R4 held while clock high", gate_en, 1);
      src_clk_lvl = 1'b0;
      k = 0;
      while (state_o != 3 && k < 50) begin cycles(1); k++; end
      check("R4 gate off in STOPPED", gate_en, 0);
      check("R5 reset not with gate edge", dll_rst, 0);
      cycles(1);
      k = 0;
      while (dll_rst && k < 50) begin k++; cycles(1); end
      check("R5 reset pulse width", k, RST_CYC);
      check("R9 relock without new request", state_o, 4);
      check("R6 freeze held in relock", freeze, 1);
      check("R6 gate held in relock", gate_en, 0);

      // R7: unfreeze and gate on one edge, accept one cycle later
      k = 0;
      while (freeze && k < 100) begin cycles(1); k++; end
      check("R7 state RUN at unfreeze", state_o, 0);
      check("R7 gate_en with unfreeze", gate_en, 1);
      check("R7 logic_rst with unfreeze", logic_rst, 0);
      check("R7 block still high", block_txn, 1);
      cycles(1);
      check("R7 block released", block_txn, 0);
      cycles(4);

      // R8: relock timeout, retry, error clears on RUN
      lock_tmo = 16'd20;
      lock_dly = 1000;
      sleep_req = 1'b1;
      cycles(6);
      sleep_req = 1'b0;
      wake_req = 1'b1;
      k = 0;
      while (state_o != 4 && k < 100) begin cycles(1); k++; end
      wake_req = 1'b0;
      k = 0;
      while (state_o == 4 && k < 100) begin cycles(1); k++; end
      check("R8 timeout cycles", k, 20);
      check("R8 error state", state_o, 5);
      check("R8 lock_err set", lock_err, 1);
      check("R8 reset re-pulsed", dll_rst, 1);
      lock_dly = 5;
      k = 0;
      while (state_o != 4 && k < 100) begin cycles(1); k++; end
      check("R8 retry relock", state_o, 4);
      check("R8 lock_err held", lock_err, 1);
      k = 0;
      while (state_o != 0 && k < 100) begin cycles(1); k++; end
      check("R8 back to RUN", state_o, 0);
      check("R8 lock_err cleared", lock_err, 0);
      cycles(4);
      finish_run();
   end

endmodule